// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a narrow port A and a wide port made of two halves, B1 and B2, each as wide as A. In the A-to-B direction, two narrow words that arrive on consecutive clocks are paired side by side on the wide port. The path into B1 is a two-register pipeline and the path into B2 is a single register. A word loaded into the B1 pipeline on one clock therefore appears on B1 in the same cycle as the word loaded into B2 on the next clock. In the B-to-A direction, each wide half is captured into its own register, and a select pin chooses which captured half appears on A.

Every data register loads on the rising clock edge only while its active-low load enable is low; otherwise it keeps its contents. The active-low output enables for the A side and the B side are also registered, so a change of bus direction takes effect one edge after it is requested. Each tri-state bus is represented by an input vector, an output vector and a drive flag. A synchronous active-high reset clears all data registers and turns off all drive.

The load enables are the only flow control. There is no valid/ready handshake and no back-pressure: the bus master decides on every clock which registers load.

Top module: `bus_exchanger`

## Requirements
- R1: On a clock edge with `rst` high, all drive flags go low and all data registers go to zero, so `a_out`, `b1_out` and `b2_out` read zero in the following cycle.
- R2: `a_drv` equals the inverse of `a_oe_n` as sampled at the previous edge. `b1_drv` and `b2_drv` both equal the inverse of `b_oe_n` as sampled at the previous edge. This holds for all four combinations of the two enables.
- R3: When `ld_a2_n` is low at an edge, `b2_out` takes the value of `a_in` sampled at that edge (one-edge latency).
- R4: When `ld_a1_n` is low at two successive edges, `b1_out` after the second edge equals `a_in` sampled at the first edge (two-edge latency).
- R5: When `ld_a1_n` is high at an edge, both stages of the B1 pipeline keep their contents, so `b1_out` is unchanged. When `ld_a2_n` is high at an edge, `b2_out` is unchanged.
- R6: The following sequence leaves `b1_out` equal to W0 and `b2_out` equal to W1 in the same cycle: W0 is presented with only `ld_a1_n` low, then W1 is presented on the next clock with both A-side load enables low.
- R7: When `ld_b1_n` (or `ld_b2_n`) is low at an edge, the B1 (or B2) capture register takes `b1_in` (or `b2_in`). When the enable is high, the register holds.
- R8: `a_out` shows the B1 capture register when `half_sel` is 1 and the B2 capture register when `half_sel` is 0. A change of `half_sel` takes effect without a clock edge.
- R9: Data registers load and hold regardless of the output enables. Data loaded while drive is off is visible as soon as drive is turned on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_oe_n | input | 1 | A-side output enable request, active low, registered |
| b_oe_n | input | 1 | B-side output enable request, active low, registered |
| ld_a1_n | input | 1 | Load enable for both B1 pipeline stages, active low |
| ld_a2_n | input | 1 | Load enable for the B2 register, active low |
| ld_b1_n | input | 1 | Load enable for the B1 capture register, active low |
| ld_b2_n | input | 1 | Load enable for the B2 capture register, active low |
| half_sel | input | 1 | 1 selects B1 capture onto A, 0 selects B2 capture |
| a_in | input | NARROW_W | Narrow port data in |
| a_out | output | NARROW_W | Narrow port data out |
| a_drv | output | 1 | Narrow port drive flag |
| b1_in | input | NARROW_W | Wide port low half data in |
| b1_out | output | NARROW_W | Wide port low half data out |
| b1_drv | output | 1 | Low half drive flag |
| b2_in | input | NARROW_W | Wide port high half data in |
| b2_out | output | NARROW_W | Wide port high half data out |
| b2_drv | output | 1 | High half drive flag |

## Verification
The assertions that look one or two edges back assume that reset is asserted for at least one edge before any of them can fire. They also assume that every control and data input is stable across each rising edge, since all behaviour is defined by the values sampled there. The stimulus changes inputs only on falling edges and holds reset through the first three edges. It applies `half_sel` changes between edges, and the A-side checks are written to tolerate such changes.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  // bit 0: narrow side drives, bit 1: wide side drives
  typedef enum logic [1:0] {
    DRV_OFF  = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10,
    DRV_BOTH = 2'b11
  } drive_mode_e;

  function automatic logic mode_drives_a(drive_mode_e m);
    return (m == DRV_A) || (m == DRV_BOTH);
  endfunction

  function automatic logic mode_drives_b(drive_mode_e m);
    return (m == DRV_B) || (m == DRV_BOTH);
  endfunction

endpackage

// File: rtl/xchg_oe_reg.sv
module xchg_oe_reg
  import xchg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        a_oe_n,
  input  logic        b_oe_n,
  output drive_mode_e mode
);

  logic a_off_q;
  logic b_off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_off_q <= 1'b1;
      b_off_q <= 1'b1;
    end else begin
      a_off_q <= a_oe_n;
      b_off_q <= b_oe_n;
    end
  end

  assign mode = drive_mode_e'({~b_off_q, ~a_off_q});

  // R1: reset leaves every bus undriven
  a_r1_reset_off: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mode == DRV_OFF);

endmodule

// File: rtl/xchg_a2b_path.sv
module xchg_a2b_path #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         ld1_n,
  input  logic         ld2_n,
  output logic [W-1:0] b1_q,
  output logic [W-1:0] b2_q
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [W-1:0]             hi_q;

  // B1 path: every stage shares the one load enable
  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
    end else if (!ld1_n) begin
      pipe_q[0] <= a_in;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  // B2 path: single register
  always_ff @(posedge clk) begin
    if (rst)         hi_q <= '0;
    else if (!ld2_n) hi_q <= a_in;
  end

  assign b1_q = pipe_q[LAST];
  assign b2_q = hi_q;

  // R3: one-edge latency into B2
  a_r3_b2_load: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(ld2_n) |-> b2_q == $past(a_in));

  // R5: held enables keep both outputs
  a_r5_b1_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(ld1_n) |-> $stable(b1_q));
  a_r5_b2_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(ld2_n) |-> $stable(b2_q));

  generate
    if (STAGES == 2) begin : g_two_stage_chk
      // R4: two-edge latency into B1
      a_r4_b1_latency: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(rst, 2) && !$past(ld1_n) && !$past(ld1_n, 2)
        |-> b1_q == $past(a_in, 2));
    end
  endgenerate

endmodule

// File: rtl/xchg_b2a_path.sv
module xchg_b2a_path #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         ld1_n,
  input  logic         ld2_n,
  input  logic         sel,
  output logic [W-1:0] a_out
);

  logic [1:0][W-1:0] cap_q;
  logic [1:0][W-1:0] cap_in;
  logic [1:0]        cap_ld_n;

  assign cap_in   = {b2_in, b1_in};
  assign cap_ld_n = {ld2_n, ld1_n};

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      always_ff @(posedge clk) begin
        if (rst)              cap_q[h] <= '0;
        else if (!cap_ld_n[h]) cap_q[h] <= cap_in[h];
      end
    end
  endgenerate

  assign a_out = sel ? cap_q[0] : cap_q[1];

  // R7/R8: a fresh capture is what A shows for the selected half
  a_r8_sel_b1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && sel && !$past(ld1_n) |-> a_out == $past(b1_in));
  a_r8_sel_b2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !sel && !$past(ld2_n) |-> a_out == $past(b2_in));
  // R7: selected half holds when its enable was high
  a_r7_hold_b1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && sel && $past(sel) && $past(ld1_n) |-> $stable(a_out));

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import xchg_pkg::*;
#(
  parameter int NARROW_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                a_oe_n,
  input  logic                b_oe_n,
  input  logic                ld_a1_n,
  input  logic                ld_a2_n,
  input  logic                ld_b1_n,
  input  logic                ld_b2_n,
  input  logic                half_sel,
  input  logic [NARROW_W-1:0] a_in,
  output logic [NARROW_W-1:0] a_out,
  output logic                a_drv,
  input  logic [NARROW_W-1:0] b1_in,
  output logic [NARROW_W-1:0] b1_out,
  output logic                b1_drv,
  input  logic [NARROW_W-1:0] b2_in,
  output logic [NARROW_W-1:0] b2_out,
  output logic                b2_drv
);

  localparam int B1_STAGES = 2;

  drive_mode_e mode;

  xchg_oe_reg u_oe (
    .clk    (clk),
    .rst    (rst),
    .a_oe_n (a_oe_n),
    .b_oe_n (b_oe_n),
    .mode   (mode)
  );

  xchg_a2b_path #(.W(NARROW_W), .STAGES(B1_STAGES)) u_a2b (
    .clk   (clk),
    .rst   (rst),
    .a_in  (a_in),
    .ld1_n (ld_a1_n),
    .ld2_n (ld_a2_n),
    .b1_q  (b1_out),
    .b2_q  (b2_out)
  );

  xchg_b2a_path #(.W(NARROW_W)) u_b2a (
    .clk   (clk),
    .rst   (rst),
    .b1_in (b1_in),
    .b2_in (b2_in),
    .ld1_n (ld_b1_n),
    .ld2_n (ld_b2_n),
    .sel   (half_sel),
    .a_out (a_out)
  );

  assign a_drv  = mode_drives_a(mode);
  assign b1_drv = mode_drives_b(mode);
  assign b2_drv = mode_drives_b(mode);

  // R2: drive flags follow the enables sampled one edge earlier
  a_r2_a_drive: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> a_drv == !$past(a_oe_n));
  a_r2_b_drive: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (b1_drv == !$past(b_oe_n)) && (b2_drv == b1_drv));

  // R6: a W0-only load followed by a joint load pairs the words
  a_r6_pairing: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(rst, 2) && !$past(ld_a1_n, 2) && !$past(ld_a1_n)
    && !$past(ld_a2_n) |-> (b1_out == $past(a_in, 2)) && (b2_out == $past(a_in)));

endmodule

// File: tb/bus_exchanger_tb_top.sv
`timescale 1ns/1ps
module bus_exchanger_tb_top;

  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_oe_n = 1'b1, b_oe_n = 1'b1;
  logic ld_a1_n = 1'b1, ld_a2_n = 1'b1, ld_b1_n = 1'b1, ld_b2_n = 1'b1;
  logic half_sel = 1'b0;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drv, b1_drv, b2_drv;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  logic [W-1:0] m_pipe[$];
  logic [W-1:0] m_b2, m_c1, m_c2;
  bit m_adrv, m_bdrv;

  always #2 clk = ~clk;

  bus_exchanger #(.NARROW_W(W)) dut_i (
    .clk(clk), .rst(rst), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
    .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n), .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n),
    .half_sel(half_sel),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
    .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "a_out",  a_out,  half_sel ? m_c1 : m_c2);
    chk(tag, "b1_out", b1_out, m_pipe[0]);
    chk(tag, "b2_out", b2_out, m_b2);
    chk(tag, "a_drv",  a_drv,  m_adrv);
    chk(tag, "b1_drv", b1_drv, m_bdrv);
    chk(tag, "b2_drv", b2_drv, m_bdrv);
  endtask

  task automatic model_edge();
    if (rst) begin
      m_pipe = '{'0, '0};
      m_b2 = '0; m_c1 = '0; m_c2 = '0;
      m_adrv = 0; m_bdrv = 0;
    end else begin
      if (!ld_a1_n) begin
        m_pipe.push_back(a_in);
        void'(m_pipe.pop_front());
      end
      if (!ld_a2_n) m_b2 = a_in;
      if (!ld_b1_n) m_c1 = b1_in;
      if (!ld_b2_n) m_c2 = b2_in;
      m_adrv = !a_oe_n;
      m_bdrv = !b_oe_n;
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle_loads();
    ld_a1_n = 1; ld_a2_n = 1; ld_b1_n = 1; ld_b2_n = 1;
  endtask

  initial begin
    m_pipe = '{'0, '0};
    m_b2 = '0; m_c1 = '0; m_c2 = '0; m_adrv = 0; m_bdrv = 0;
    // R1: reset with loads requested and enables low
    a_oe_n = 0; b_oe_n = 0; ld_a1_n = 0; ld_a2_n = 0; a_in = 12'hABC;
    repeat (3) step("R1");
    rst = 0; idle_loads(); a_oe_n = 1; b_oe_n = 1;
    step("R1");

    // R2: all four enable combinations
    a_oe_n = 0; b_oe_n = 1; step("R2");
    chk("R2", "a_drv only", {a_drv, b1_drv, b2_drv}, 3'b100);
    a_oe_n = 1; b_oe_n = 0; step("R2");
    chk("R2", "b only", {a_drv, b1_drv, b2_drv}, 3'b011);
    a_oe_n = 0; b_oe_n = 0; step("R2");
    chk("R2", "both", {a_drv, b1_drv, b2_drv}, 3'b111);
    a_oe_n = 1; b_oe_n = 1; step("R2");
    chk("R2", "none", {a_drv, b1_drv, b2_drv}, 3'b000);

    // R3: single-register path into B2
    a_oe_n = 0; b_oe_n = 0;
    ld_a2_n = 0; a_in = 12'h5A5; step("R3");
    chk("R3", "b2 one edge", b2_out, 12'h5A5);
    a_in = 12'h0F0; step("R3");
    chk("R3", "b2 reload", b2_out, 12'h0F0);

    // R4: two-edge latency into B1
    ld_a2_n = 1; ld_a1_n = 0; a_in = 12'h111; step("R4");
    chk("R4", "b1 not yet", b1_out, 12'h000);
    a_in = 12'h222; step("R4");
    chk("R4", "b1 after two", b1_out, 12'h111);

    // R5: holds with enables high, data changing
    ld_a1_n = 1; ld_a2_n = 1; a_in = 12'hFFF; step("R5");
    step("R5");
    chk("R5", "b1 held", b1_out, 12'h111);
    chk("R5", "b2 held", b2_out, 12'h0F0);
    ld_a1_n = 0; a_in = 12'h333; step("R5");
    chk("R5", "stage held then shifts", b1_out, 12'h222);

    // R6: pairing of two consecutive words
    ld_a1_n = 0; ld_a2_n = 1; a_in = 12'hC0D; step("R6");
    ld_a1_n = 0; ld_a2_n = 0; a_in = 12'hE1F; step("R6");
    chk("R6", "b1 is W0", b1_out, 12'hC0D);
    chk("R6", "b2 is W1", b2_out, 12'hE1F);
    idle_loads();

    // R7: B-side captures and holds
    ld_b1_n = 0; b1_in = 12'h1B1; b2_in = 12'h2B2; half_sel = 1; step("R7");
    chk("R7", "b1 capture", a_out, 12'h1B1);
    ld_b1_n = 1; ld_b2_n = 0; b1_in = 12'h999; step("R7");
    chk("R7", "b1 hold", a_out, 12'h1B1);
    ld_b2_n = 1;

    // R8: select changes without a clock
    half_sel = 0; #0.5;
    chk("R8", "sel low -> b2", a_out, 12'h2B2);
    half_sel = 1; #0.5;
    chk("R8", "sel high -> b1", a_out, 12'h1B1);
    step("R8");

    // R9: loads while drive off, then turn drive on
    a_oe_n = 1; b_oe_n = 1;
    ld_a2_n = 0; ld_b2_n = 0; a_in = 12'h7E7; b2_in = 12'h6D6; half_sel = 0;
    step("R9");
    idle_loads(); a_oe_n = 0; b_oe_n = 0; step("R9");
    chk("R9", "b2 loaded while off", b2_out, 12'h7E7);
    chk("R9", "a loaded while off", a_out, 12'h6D6);
    chk("R9", "drive now on", {a_drv, b1_drv}, 2'b11);

    // mixed random traffic compared every clock
    for (int i = 0; i < 400; i++) begin
      {a_oe_n, b_oe_n, ld_a1_n, ld_a2_n, ld_b1_n, ld_b2_n, half_sel} = 7'($urandom);
      a_in = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
      step("R9");
    end

    // R1: reset in mid-run
    rst = 1; step("R1");
    rst = 0; idle_loads(); a_oe_n = 1; b_oe_n = 1; step("R1");
    chk("R1", "outputs cleared", {b1_out, b2_out}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule